// File: doc/BRIEF.md
# DRAM Error Address Unhash and Normalizer

This block takes the device-level address of a DRAM error and turns it into a normalized address. The 28-bit input holds a column, a bank, a row, a pseudochannel bit and a stack ID. The memory controller may have scrambled the bank and pseudochannel bits with XOR hashes. The block recovers the physical bank and pseudochannel from parity masks that software programs. It then scatters every field into a fixed, interleaved 31-bit layout that a downstream stage uses to reach the system address.

Six configuration slots are written through a single-cycle write port selected by `cfg_sel_i`. Slots 0 to 3 hold the hash for bank bits 0 to 3. Slot 4 holds the pseudochannel hash. Slot 5 holds a 6-bit mask over an extended bank vector. Every hash slot shares one layout: bit 0 enables the hash, bits 5:1 hold the column mask (the field runs to bit 13, and its upper bits have no effect), and bits 28:14 hold the row mask (the field runs to bit 31, and its upper bits have no effect).

Addresses enter through a valid/ready handshake. The result is registered and held until the consumer takes it, so the latency is one cycle.

Top module: `dram_addr_norm`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1, and every hash is disabled with all masks zero.
- R2: The input fields are: bit 0 unused, column = bits 5:1, bank = bits 9:6, row = bits 24:10, pseudochannel = bit 25, stack = bits 27:26. The output is {stack, row[13:0], col[4], bank[1:0], bank[3:2], col[3:2], pc, col[1:0], 5'b0}, from MSB to LSB.
- R3: Row bit 14 has no effect on the output.
- R4: When slot i (0 to 3) is enabled, bank bit i is inverted by parity(col & colmask) XOR parity(row & rowmask) of that slot.
- R5: When slot 4 is enabled, the pseudochannel bit is inverted by the XOR of three parities: the masked column, the masked row, and the extended bank vector ANDed with slot 5 bits 5:0. The bank in this vector is the value after R4 has been applied.
- R6: The extended bank vector is {stack[1:0], 1'b0, bank[3:0]}, with bit 6 as the MSB. Because the mask covers only bits 5:0, stack bit 1 never changes the pseudochannel.
- R7: A slot with its enable bit clear leaves its bit unchanged, whatever its masks hold.
- R8: A configuration write in the same cycle as an accepted input does not affect that input's result. It applies from the next accepted input onward.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_addr_o` hold their values.
- R10: `in_ready_o` = !out_valid_o | out_ready_i. An accepted input appears as `out_valid_o` = 1 on the next cycle. If no input is accepted, a consumed output clears `out_valid_o`.
- R11: Writes with `cfg_sel_i` of 6 or 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration slot select |
| cfg_wdata_i | input | 32 | Configuration write data |
| in_valid_i | input | 1 | Input address valid |
| in_ready_o | output | 1 | Block can accept an input |
| in_addr_i | input | 28 | DRAM error address |
| out_valid_o | output | 1 | Normalized address valid |
| out_ready_i | input | 1 | Consumer takes the output |
| out_addr_o | output | 31 | Normalized address |

## Verification
A configuration write and an input acceptance can land on the same clock edge. A write and an output stall can also overlap. The bench writes a slot in the exact cycle it presents an address. Its reference model converts that address with the slot contents from before the edge and applies the write afterwards, so any leak of the new mask into the result shows up as a mismatch. A randomized phase mixes backpressure, random writes (including the unused selects) and bursts of inputs, and compares the outputs against the model on every clock.

// File: rtl/dram_norm_pkg.sv
`timescale 1ns/1ps
package dram_norm_pkg;
  localparam int COL_W    = 5;
  localparam int BANK_W   = 4;
  localparam int ROW_W    = 15;
  localparam int SID_W    = 2;
  localparam int IN_W     = 28;
  localparam int NA_W     = 31;
  localparam int NA_ROW_W = 14;
  localparam int CFG_W    = 32;
  localparam int SEL_W    = 3;
  localparam int BMASK_W  = 6;
  localparam int EXT_W    = SID_W + 1 + BANK_W;

  localparam int COL_LSB  = 1;
  localparam int BANK_LSB = COL_LSB + COL_W;
  localparam int ROW_LSB  = BANK_LSB + BANK_W;
  localparam int PC_BIT   = ROW_LSB + ROW_W;
  localparam int SID_LSB  = PC_BIT + 1;

  localparam int CMASK_LSB = 1;
  localparam int RMASK_LSB = 14;

  localparam int SEL_PC    = BANK_W;
  localparam int SEL_BMASK = BANK_W + 1;

  typedef struct packed {
    logic             en;
    logic [COL_W-1:0] col_m;
    logic [ROW_W-1:0] row_m;
  } hash_t;

  typedef struct packed {
    logic [SID_W-1:0]  sid;
    logic              pc;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } dram_f_t;

  function automatic hash_t unpack_hash(logic [CFG_W-1:0] r);
    hash_t h;
    h.en    = r[0];
    h.col_m = r[CMASK_LSB +: COL_W];
    h.row_m = r[RMASK_LSB +: ROW_W];
    return h;
  endfunction

  function automatic dram_f_t split_addr(logic [IN_W-1:0] a);
    dram_f_t f;
    f.col  = a[COL_LSB  +: COL_W];
    f.bank = a[BANK_LSB +: BANK_W];
    f.row  = a[ROW_LSB  +: ROW_W];
    f.pc   = a[PC_BIT];
    f.sid  = a[SID_LSB  +: SID_W];
    return f;
  endfunction
endpackage

// File: rtl/dram_hash_cfg.sv
`timescale 1ns/1ps
module dram_hash_cfg
  import dram_norm_pkg::*;
#(
  parameter int NB = BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output hash_t [NB-1:0]      bank_hash_o,
  output hash_t               pc_hash_o,
  output logic [BMASK_W-1:0]  bmask_o
);
  // only mask bits that can meet a field are stored
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[CFG_W-1:RMASK_LSB+ROW_W],
                          wdata_i[RMASK_LSB-1:CMASK_LSB+COL_W]};

  for (genvar i = 0; i < NB; i++) begin : g_bank
    hash_t r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r_q <= '0;
      else if (we_i && sel_i == SEL_W'(i))  r_q <= unpack_hash(wdata_i);
    end
    assign bank_hash_o[i] = r_q;
  end

  hash_t               pc_q;
  logic [BMASK_W-1:0]  bm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      bm_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_W'(SEL_PC))    pc_q <= unpack_hash(wdata_i);
      if (sel_i == SEL_W'(SEL_BMASK)) bm_q <= wdata_i[BMASK_W-1:0];
    end
  end

  assign pc_hash_o = pc_q;
  assign bmask_o   = bm_q;
endmodule

// File: rtl/dram_bank_unhash.sv
`timescale 1ns/1ps
module dram_bank_unhash
  import dram_norm_pkg::*;
#(
  parameter int NB = BANK_W
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [NB-1:0]     bank_i,
  input  hash_t [NB-1:0]    hash_i,
  output logic [NB-1:0]     bank_o
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic flip;
    assign flip = hash_i[i].en &
                  ((^(col_i & hash_i[i].col_m)) ^ (^(row_i & hash_i[i].row_m)));
    assign bank_o[i] = bank_i[i] ^ flip;
  end
endmodule

// File: rtl/dram_pc_unhash.sv
`timescale 1ns/1ps
module dram_pc_unhash
  import dram_norm_pkg::*;
(
  input  logic [COL_W-1:0]   col_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [SID_W-1:0]   sid_i,
  input  logic               pc_i,
  input  hash_t              hash_i,
  input  logic [BMASK_W-1:0] bmask_i,
  output logic               pc_o
);
  logic [EXT_W-1:0] ext_bank;
  logic [EXT_W-1:0] ext_mask;
  logic             par;

  // stack rides above the bank; mask is narrower than the vector
  assign ext_bank = {sid_i, 1'b0, bank_i};
  assign ext_mask = {{(EXT_W-BMASK_W){1'b0}}, bmask_i};
  assign par  = (^(col_i & hash_i.col_m)) ^ (^(row_i & hash_i.row_m)) ^
                (^(ext_bank & ext_mask));
  assign pc_o = pc_i ^ (hash_i.en & par);
endmodule

// File: rtl/dram_na_pack.sv
`timescale 1ns/1ps
module dram_na_pack
  import dram_norm_pkg::*;
(
  input  logic [COL_W-1:0]    col_i,
  input  logic [NA_ROW_W-1:0] row_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [SID_W-1:0]    sid_i,
  input  logic                pc_i,
  output logic [NA_W-1:0]     na_o
);
  assign na_o = {sid_i, row_i, col_i[4], bank_i[1:0], bank_i[3:2],
                 col_i[3:2], pc_i, col_i[1:0], 5'b0};
endmodule

// File: rtl/dram_addr_norm.sv
`timescale 1ns/1ps
module dram_addr_norm
  import dram_norm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [NA_W-1:0]   out_addr_o
);
  dram_f_t              f;
  hash_t [BANK_W-1:0]   bank_hash;
  hash_t                pc_hash;
  logic [BMASK_W-1:0]   bmask;
  logic [BANK_W-1:0]    bank_un;
  logic                 pc_un;
  logic [NA_W-1:0]      na;
  logic                 accept;
  logic                 out_valid_q;
  logic [NA_W-1:0]      out_addr_q;
  logic                 unused_lsb;

  assign f          = split_addr(in_addr_i);
  assign unused_lsb = in_addr_i[0];

  dram_hash_cfg #(.NB(BANK_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .wdata_i     (cfg_wdata_i),
    .bank_hash_o (bank_hash),
    .pc_hash_o   (pc_hash),
    .bmask_o     (bmask)
  );

  dram_bank_unhash #(.NB(BANK_W)) u_bank (
    .col_i  (f.col),
    .row_i  (f.row),
    .bank_i (f.bank),
    .hash_i (bank_hash),
    .bank_o (bank_un)
  );

  dram_pc_unhash u_pc (
    .col_i   (f.col),
    .row_i   (f.row),
    .bank_i  (bank_un),
    .sid_i   (f.sid),
    .pc_i    (f.pc),
    .hash_i  (pc_hash),
    .bmask_i (bmask),
    .pc_o    (pc_un)
  );

  dram_na_pack u_pack (
    .col_i  (f.col),
    .row_i  (f.row[NA_ROW_W-1:0]),
    .bank_i (bank_un),
    .sid_i  (f.sid),
    .pc_i   (pc_un),
    .na_o   (na)
  );

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      out_addr_q  <= na;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_addr_o  = out_addr_q;
endmodule

// File: rtl/dram_addr_norm_chk.sv
`timescale 1ns/1ps
module dram_addr_norm_chk
  import dram_norm_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [NA_W-1:0] out_addr_o
);
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)); // R9

  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R10

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R10

  AST_DRAIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R10

  AST_ADDR_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> $stable(out_addr_o)); // R8
endmodule

bind dram_addr_norm dram_addr_norm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o)
);

// File: tb/dram_addr_norm_bench.sv
`timescale 1ns/1ps
module dram_addr_norm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [27:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [30:0] out_addr;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_cfg [6];
  logic        m_valid = 1'b0;
  logic [30:0] m_addr  = '0;

  always #5 clk = ~clk;

  dram_addr_norm u_dram_addr_norm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_addr_i   (in_addr),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_addr_o  (out_addr)
  );

  function automatic int par(int unsigned v);
    return $countones(v) % 2;
  endfunction

  function automatic logic [30:0] ref_conv(logic [27:0] a);
    int unsigned col, bank, row, pc, sid, cm, rm, p, na;
    col  = (a >> 1) & 32'h1F;
    bank = (a >> 6) & 32'hF;
    row  = (a >> 10) & 32'h7FFF;
    pc   = (a >> 25) & 1;
    sid  = (a >> 26) & 3;
    for (int i = 0; i < 4; i++) begin
      if (m_cfg[i][0]) begin
        cm = (m_cfg[i] >> 1) & 32'h1FFF;
        rm = m_cfg[i] >> 14;
        p  = par(col & cm) ^ par(row & rm);
        bank = bank ^ (p << i);
      end
    end
    if (m_cfg[4][0]) begin
      cm = (m_cfg[4] >> 1) & 32'h1FFF;
      rm = m_cfg[4] >> 14;
      p  = par(col & cm) ^ par(row & rm) ^
           par((bank | (sid << 5)) & (m_cfg[5] & 32'h3F));
      pc = pc ^ p;
    end
    na = sid * (1 << 29) + (row % (1 << 14)) * (1 << 15) + ((col >> 4) & 1) * (1 << 14)
       + (bank & 3) * (1 << 12) + ((bank >> 2) & 3) * (1 << 10)
       + ((col >> 2) & 3) * (1 << 8) + pc * (1 << 7) + (col & 3) * (1 << 5);
    return na[30:0];
  endfunction

  initial for (int i = 0; i < 6; i++) m_cfg[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      for (int i = 0; i < 6; i++) m_cfg[i] <= '0;
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid <= 1'b1;
        m_addr  <= ref_conv(in_addr);
      end else if (out_ready) begin
        m_valid <= 1'b0;
      end
      if (cfg_we && cfg_sel < 3'd6) m_cfg[cfg_sel] <= cfg_wdata;
    end
  end

  task automatic check();
    logic exp_ready;
    exp_ready = !m_valid || out_ready;
    checks++;
    if (out_valid !== m_valid || in_ready !== exp_ready ||
        (m_valid && out_addr !== m_addr) || (tag == "R1" && out_addr !== '0)) begin
      fails++;
      $display("FAIL %s: valid=%b ready=%b addr=%h expected valid=%b ready=%b addr=%h",
               tag, out_valid, in_ready, out_addr, m_valid, exp_ready, m_addr);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic send(logic [27:0] a);
    in_valid = 1'b1;
    in_addr  = a;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic wcfg(logic [2:0] s, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    @(negedge clk); check();
    @(negedge clk); check();
    rst_n = 1'b1;
    tick();

    // R2: field packing with all hashes off
    tag = "R2";
    send(28'h0000002); send(28'h0000040); send(28'h0000400);
    send(28'h2000000); send(28'h4000000); send(28'hFFFFFFE);
    for (int i = 0; i < 8; i++) send(28'($urandom));
    tick();

    // R3: row bit 14 dropped
    tag = "R3";
    send(28'h1000000); send(28'h1FFFC00); send(28'h1000000 | 28'($urandom));

    // R7: enables clear, masks full
    tag = "R7";
    for (int i = 0; i < 5; i++) wcfg(3'(i), 32'hFFFF_FFFE);
    wcfg(3'd5, 32'h3F);
    for (int i = 0; i < 8; i++) send(28'($urandom));

    // R4: bank hashes only
    tag = "R4";
    wcfg(3'd4, 32'h0);
    wcfg(3'd0, 32'h0000_4003);
    wcfg(3'd1, 32'h0001_0005);
    wcfg(3'd2, $urandom | 32'h1);
    wcfg(3'd3, $urandom | 32'h1);
    send(28'h0000402); send(28'h0000C06);
    for (int i = 0; i < 10; i++) send(28'($urandom));

    // R5: pseudochannel hash from column and row
    tag = "R5";
    wcfg(3'd5, 32'h0);
    wcfg(3'd4, 32'h0000_C003);
    send(28'h0000002); send(28'h0000C00);
    for (int i = 0; i < 10; i++) send(28'($urandom));

    // R6: extended bank term; stack bit 1 never counts
    tag = "R6";
    wcfg(3'd4, 32'h1);
    wcfg(3'd5, 32'h3F);
    send(28'h8000000); send(28'h4000000); send(28'hC000040);
    for (int i = 0; i < 6; i++) send(28'($urandom));
    wcfg(3'd5, 32'h20);
    send(28'h4000000); send(28'h8000000);

    // R8: write in the same cycle as an accepted input
    tag = "R8";
    wcfg(3'd0, 32'h0);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000_0003;
    in_valid = 1'b1; in_addr = 28'h0000002;
    tick();
    cfg_we = 1'b0;
    in_addr = 28'h0000002;
    tick();
    in_valid = 1'b0;
    tick();

    // R11: unused selects leave every slot untouched
    tag = "R11";
    wcfg(3'd6, 32'hFFFF_FFFF);
    wcfg(3'd7, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) send(28'($urandom));

    // R9 / R10: backpressure with random writes and traffic
    tag = "R9_R10";
    for (int i = 0; i < 400; i++) begin
      out_ready = 1'($urandom % 3 != 0);
      in_valid  = 1'($urandom);
      in_addr   = 28'($urandom);
      cfg_we    = 1'($urandom % 5 == 0);
      cfg_sel   = 3'($urandom);
      cfg_wdata = $urandom;
      tick();
    end
    in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
    tick(); tick();

    finish_run();
  end
endmodule